// File: doc/BRIEF.md
# Banked Nibble Data Memory Address Decoder

This block turns a data access issued by a 4-bit processor core into a physical address for a nibble-wide data memory of up to sixteen 256-nibble banks. The core supplies the 8-bit operand address, whether the access is direct or indirect, whether it is a stack access, the access width (single bit, nibble, or nibble pair) and a write strobe. It also supplies the current bank-enable flag and the 4-bit bank selection. The decoder returns the physical nibble address of the addressed nibble, and also of its partner for a pair access. It returns a region tag for the addressed location, an illegal-access flag and two per-nibble write enables.

The whole decode is combinational. A pair access is served through a paired port: both nibble addresses are valid in the same cycle, and a legal pair write raises both write enables together. The memory arrays and the peripheral registers sit outside this block. They consume the addresses and enables.

Top module: `nbank_decoder`

## Requirements
- R1: A stack access (`stack_i`=1) maps to bank 0, with physical address {0h, addr}. The bank-enable flag and the bank selection have no effect, and a stack access never raises the illegal flag through the bank selection.
- R2: With `emb_i`=0, a direct access (`indirect_i`=0) to 00h–7Fh maps to bank 0 (physical 000h–07Fh).
- R3: With `emb_i`=0, a direct access to 80h–FFh maps to the I/O bank 15 (physical F80h–FFFh).
- R4: With `emb_i`=0, an indirect access maps to bank 0 (physical 000h–0FFh) for every address.
- R5: With `emb_i`=1, a non-stack access maps to {`smb_i`, addr}.
- R6: `region_o` gives the region of `phys_lo_o`: 0 = working registers (000h–01Fh), 1 = stack/general (020h–0FFh), 2 = general (100h–1DFh), 3 = LCD data (1E0h–1FFh), 4 = peripheral I/O (F80h–FFFh), 7 = unmapped (any other address).
- R7: Width codes are 0 = bit, 1 = nibble, 2 = pair, 3 = reserved. For a pair access `phys_hi_o` equals `phys_lo_o` with bit 0 set. For any other width `phys_hi_o` equals `phys_lo_o`.
- R8: A pair access with an odd address raises `illegal_o`.
- R9: A pair access whose region is LCD data raises `illegal_o`. Bit and nibble accesses to LCD data are legal.
- R10: With `emb_i`=1, a non-stack access with `smb_i` other than 0, 1 or 15 raises `illegal_o`.
- R11: An access to an unmapped address (region 7), or one with the reserved width code, raises `illegal_o`.
- R12: `we_lo_o` = `wr_i` and not illegal. `we_hi_o` = `we_lo_o` and pair width. So an illegal write enables no nibble, and a legal pair write enables both nibbles in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| addr_i | input | 8 | Operand address from the instruction |
| indirect_i | input | 1 | 1 = indirect (pointer) addressing, 0 = direct |
| stack_i | input | 1 | 1 = stack access, banking ignored |
| width_i | input | 2 | Access width code (0 bit, 1 nibble, 2 pair, 3 reserved) |
| emb_i | input | 1 | Bank-enable flag |
| smb_i | input | 4 | Selected memory bank |
| wr_i | input | 1 | Write strobe |
| phys_lo_o | output | 12 | Physical address of the addressed nibble |
| phys_hi_o | output | 12 | Physical address of the upper nibble of a pair |
| region_o | output | 3 | Region tag of phys_lo_o |
| illegal_o | output | 1 | Access is not permitted |
| we_lo_o | output | 1 | Write enable for phys_lo_o |
| we_hi_o | output | 1 | Write enable for phys_hi_o |

## Verification
Several illegal conditions can coincide in one vector. The hardest case to reach is one where a single rule alone decides the flag: a pair access that is even and mapped, but falls in the LCD area, reached only with the bank-enable flag set and bank 1 selected. Another is a bank-15 access with the flag set below F80h, which is unmapped. The stimulus therefore sweeps every combination of address, width, mode, stack flag, bank-enable flag, bank selection and write strobe. Each of these isolated cases then appears, alongside its neighbours that differ in only one input.

// File: rtl/nbank_pkg.sv
package nbank_pkg;

    typedef enum logic [1:0] {
        WID_BIT  = 2'd0,
        WID_NIB  = 2'd1,
        WID_PAIR = 2'd2,
        WID_RSVD = 2'd3
    } width_e;

    typedef enum logic [2:0] {
        RGN_WORK   = 3'd0,
        RGN_STKGEN = 3'd1,
        RGN_GEN    = 3'd2,
        RGN_LCD    = 3'd3,
        RGN_PERIPH = 3'd4,
        RGN_NONE   = 3'd7
    } region_e;

endpackage

// File: rtl/nbank_window.sv
// Resolves which bank an access lands in, from mode, bank-enable and selection.
module nbank_window #(
    parameter int ADDR_W  = 8,
    parameter int BANK_W  = 4,
    parameter int IO_BANK = 15
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              indirect,
    input  logic              stack,
    input  logic              emb,
    input  logic [BANK_W-1:0] smb,
    output logic [BANK_W-1:0] bank,
    output logic              bank_bad
);
    localparam logic [BANK_W-1:0] IO_B   = BANK_W'(IO_BANK);
    localparam logic [BANK_W-1:0] BANK_0 = '0;
    localparam logic [BANK_W-1:0] BANK_1 = BANK_W'(1);

    always_comb begin
        bank     = BANK_0;
        bank_bad = 1'b0;
        if (stack) begin
            bank = BANK_0;
        end else if (!emb) begin
            // direct upper half is folded onto the I/O bank
            bank = (!indirect && addr[ADDR_W-1]) ? IO_B : BANK_0;
        end else begin
            bank     = smb;
            bank_bad = !((smb == BANK_0) || (smb == BANK_1) || (smb == IO_B));
        end
    end
endmodule

// File: rtl/nbank_region.sv
// Classifies a physical nibble address into its region.
module nbank_region
    import nbank_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int BANK_W    = 4,
    parameter int IO_BANK   = 15,
    parameter int WORK_NIBS = 32,
    parameter int LCD_NIBS  = 32,
    parameter int IO_NIBS   = 128
) (
    input  logic [BANK_W+ADDR_W-1:0] phys,
    output region_e                  region
);
    localparam int BANK_NIBS = 1 << ADDR_W;
    localparam int LCD_BASE  = BANK_NIBS - LCD_NIBS;
    localparam int IO_BASE   = BANK_NIBS - IO_NIBS;
    localparam logic [BANK_W-1:0] IO_B = BANK_W'(IO_BANK);

    logic [BANK_W-1:0] bank;
    logic [ADDR_W-1:0] offs;

    assign bank = phys[BANK_W+ADDR_W-1:ADDR_W];
    assign offs = phys[ADDR_W-1:0];

    always_comb begin
        region = RGN_NONE;
        if (bank == BANK_W'(0)) begin
            region = (offs < ADDR_W'(WORK_NIBS)) ? RGN_WORK : RGN_STKGEN;
        end else if (bank == BANK_W'(1)) begin
            region = (offs >= ADDR_W'(LCD_BASE)) ? RGN_LCD : RGN_GEN;
        end else if (bank == IO_B) begin
            region = (offs >= ADDR_W'(IO_BASE)) ? RGN_PERIPH : RGN_NONE;
        end
    end
endmodule

// File: rtl/nbank_guard.sv
// Legality check and per-nibble write enables.
module nbank_guard
    import nbank_pkg::*;
(
    input  logic    addr_odd,
    input  width_e  width,
    input  region_e region,
    input  logic    bank_bad,
    input  logic    wr,
    output logic    illegal,
    output logic    we_lo,
    output logic    we_hi
);
    logic is_pair;

    assign is_pair = (width == WID_PAIR);

    always_comb begin
        illegal = 1'b0;
        if (is_pair && addr_odd)         illegal = 1'b1;
        if (is_pair && region == RGN_LCD) illegal = 1'b1;
        if (bank_bad)                    illegal = 1'b1;
        if (region == RGN_NONE)          illegal = 1'b1;
        if (width == WID_RSVD)           illegal = 1'b1;
    end

    assign we_lo = wr && !illegal;
    assign we_hi = we_lo && is_pair;
endmodule

// File: rtl/nbank_decoder.sv
module nbank_decoder
    import nbank_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int BANK_W    = 4,
    parameter int IO_BANK   = 15,
    parameter int WORK_NIBS = 32,
    parameter int LCD_NIBS  = 32,
    parameter int IO_NIBS   = 128
) (
    input  logic [7:0]  addr_i,
    input  logic        indirect_i,
    input  logic        stack_i,
    input  logic [1:0]  width_i,
    input  logic        emb_i,
    input  logic [3:0]  smb_i,
    input  logic        wr_i,
    output logic [11:0] phys_lo_o,
    output logic [11:0] phys_hi_o,
    output logic [2:0]  region_o,
    output logic        illegal_o,
    output logic        we_lo_o,
    output logic        we_hi_o
);
    localparam int PHYS_W = BANK_W + ADDR_W;
    localparam int LANES  = 2;

    logic [BANK_W-1:0] bank;
    logic              bank_bad;
    logic [PHYS_W-1:0] phys;
    logic [PHYS_W-1:0] lane_addr [LANES];
    region_e           region;
    width_e            width;

    assign width = width_e'(width_i);

    nbank_window #(
        .ADDR_W (ADDR_W),
        .BANK_W (BANK_W),
        .IO_BANK(IO_BANK)
    ) u_window (
        .addr    (addr_i),
        .indirect(indirect_i),
        .stack   (stack_i),
        .emb     (emb_i),
        .smb     (smb_i),
        .bank    (bank),
        .bank_bad(bank_bad)
    );

    assign phys = {bank, addr_i};

    // lane 0 carries the addressed nibble, lane 1 its pair partner
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        if (g == 0) begin : g_low
            assign lane_addr[g] = phys;
        end else begin : g_high
            assign lane_addr[g] = (width == WID_PAIR) ? (phys | PHYS_W'(1)) : phys;
        end
    end

    nbank_region #(
        .ADDR_W   (ADDR_W),
        .BANK_W   (BANK_W),
        .IO_BANK  (IO_BANK),
        .WORK_NIBS(WORK_NIBS),
        .LCD_NIBS (LCD_NIBS),
        .IO_NIBS  (IO_NIBS)
    ) u_region (
        .phys  (phys),
        .region(region)
    );

    nbank_guard u_guard (
        .addr_odd(addr_i[0]),
        .width   (width),
        .region  (region),
        .bank_bad(bank_bad),
        .wr      (wr_i),
        .illegal (illegal_o),
        .we_lo   (we_lo_o),
        .we_hi   (we_hi_o)
    );

    assign phys_lo_o = lane_addr[0];
    assign phys_hi_o = lane_addr[1];
    assign region_o  = region;
endmodule

// File: rtl/nbank_decoder_checker.sv
module nbank_decoder_checker (
    input logic [7:0]  addr_i,
    input logic        indirect_i,
    input logic        stack_i,
    input logic [1:0]  width_i,
    input logic        emb_i,
    input logic [11:0] phys_lo_o,
    input logic [11:0] phys_hi_o,
    input logic [2:0]  region_o,
    input logic        illegal_o,
    input logic        we_lo_o,
    input logic        we_hi_o
);
    always_comb begin
        if (stack_i) begin
            assert_stack_bank0_R1: assert (phys_lo_o == {4'h0, addr_i})
                else $error("stack access left bank 0");
        end
        if (!stack_i && !emb_i && !indirect_i && addr_i[7]) begin
            assert_direct_io_R3: assert (phys_lo_o[11:8] == 4'hF)
                else $error("direct upper half not in I/O bank");
        end
        if (!stack_i && !emb_i && indirect_i) begin
            assert_indirect_bank0_R4: assert (phys_lo_o[11:8] == 4'h0)
                else $error("indirect access left bank 0");
        end
        if (width_i == 2'd2) begin
            assert_pair_adjacent_R7: assert (phys_hi_o == (phys_lo_o | 12'h001))
                else $error("pair partner address wrong");
        end
        if (width_i == 2'd2 && addr_i[0]) begin
            assert_odd_pair_R8: assert (illegal_o)
                else $error("odd pair not flagged");
        end
        if (width_i == 2'd2 && region_o == 3'd3) begin
            assert_lcd_pair_R9: assert (illegal_o)
                else $error("LCD pair not flagged");
        end
        if (illegal_o) begin
            assert_write_blocked_R12: assert (!we_lo_o && !we_hi_o)
                else $error("illegal access wrote");
        end
        if (we_hi_o) begin
            assert_hi_needs_lo_R12: assert (we_lo_o && width_i == 2'd2)
                else $error("upper enable without pair write");
        end
    end
endmodule

bind nbank_decoder nbank_decoder_checker u_checker (
    .addr_i    (addr_i),
    .indirect_i(indirect_i),
    .stack_i   (stack_i),
    .width_i   (width_i),
    .emb_i     (emb_i),
    .phys_lo_o (phys_lo_o),
    .phys_hi_o (phys_hi_o),
    .region_o  (region_o),
    .illegal_o (illegal_o),
    .we_lo_o   (we_lo_o),
    .we_hi_o   (we_hi_o)
);

// File: tb/nbank_decoder_tb.sv
module nbank_decoder_tb;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG_CYCLES = 150000;

    logic        clk = 1'b0;
    logic [7:0]  addr_i = '0;
    logic        indirect_i = 1'b0;
    logic        stack_i = 1'b0;
    logic [1:0]  width_i = '0;
    logic        emb_i = 1'b0;
    logic [3:0]  smb_i = '0;
    logic        wr_i = 1'b0;
    logic [11:0] phys_lo_o, phys_hi_o;
    logic [2:0]  region_o;
    logic        illegal_o, we_lo_o, we_hi_o;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    bit done   = 1'b0;

    nbank_decoder u_dut (
        .addr_i    (addr_i),
        .indirect_i(indirect_i),
        .stack_i   (stack_i),
        .width_i   (width_i),
        .emb_i     (emb_i),
        .smb_i     (smb_i),
        .wr_i      (wr_i),
        .phys_lo_o (phys_lo_o),
        .phys_hi_o (phys_hi_o),
        .region_o  (region_o),
        .illegal_o (illegal_o),
        .we_lo_o   (we_lo_o),
        .we_hi_o   (we_hi_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles >= WATCHDOG_CYCLES && !done) begin
            fails = fails + 1;
            $display("FAIL watchdog: actual %0d cycles expected < %0d", cycles, WATCHDOG_CYCLES);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic check(input string tag, input int act, input int exp);
        checks = checks + 1;
        if (act != exp) begin
            fails = fails + 1;
            $display("FAIL %s: addr=%02h ind=%0d stk=%0d w=%0d emb=%0d smb=%0d wr=%0d actual %0h expected %0h",
                     tag, addr_i, indirect_i, stack_i, width_i, emb_i, smb_i, wr_i, act, exp);
        end
    endtask

    initial begin
        for (int s = 0; s < 2; s++)
        for (int e = 0; e < 2; e++)
        for (int m = 0; m < 2; m++)
        for (int w = 0; w < 4; w++)
        for (int b = 0; b < 16; b++)
        for (int r = 0; r < 2; r++)
        for (int a = 0; a < 256; a++) begin
            int bank, phys, hi, rgn, off;
            bit bad, ill, exp_lo, exp_hi;
            string atag;
            stack_i = s[0]; emb_i = e[0]; indirect_i = m[0];
            width_i = w[1:0]; smb_i = b[3:0]; wr_i = r[0]; addr_i = a[7:0];
            #1;
            bad = 1'b0;
            if (s == 1) begin bank = 0; atag = "R1"; end
            else if (e == 0 && m == 1) begin bank = 0; atag = "R4"; end
            else if (e == 0 && a >= 128) begin bank = 15; atag = "R3"; end
            else if (e == 0) begin bank = 0; atag = "R2"; end
            else begin
                bank = b; atag = "R5";
                bad = !(b == 0 || b == 1 || b == 15);
            end
            phys = bank * 256 + a;
            off  = a;
            if (bank == 0) rgn = (off < 32) ? 0 : 1;
            else if (bank == 1) rgn = (off >= 224) ? 3 : 2;
            else if (bank == 15) rgn = (off >= 128) ? 4 : 7;
            else rgn = 7;
            hi  = (w == 2) ? (phys | 1) : phys;
            ill = 1'b0;
            if (w == 2 && (a % 2) == 1) ill = 1'b1;            // R8
            if (w == 2 && rgn == 3) ill = 1'b1;                 // R9
            if (bad) ill = 1'b1;                                // R10
            if (rgn == 7 || w == 3) ill = 1'b1;                 // R11
            exp_lo = (r == 1) && !ill;
            exp_hi = exp_lo && (w == 2);
            check(atag, int'(phys_lo_o), phys);
            check("R6", int'(region_o), rgn);
            check("R7", int'(phys_hi_o), hi);
            check((w == 2 && (a % 2) == 1) ? "R8" : (w == 2 && rgn == 3) ? "R9" :
                  bad ? "R10" : "R11", int'(illegal_o), int'(ill));
            check("R12", int'({we_hi_o, we_lo_o}), int'({exp_hi, exp_lo}));
        end
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule